// File: doc/BRIEF.md
# Per-processor compare timer interrupt unit

This block keeps one free-running counter that is shared by every processor. Each processor also has its own compare logic, which turns a match between the counter and that processor's compare value into an interrupt level on a CPU interrupt pin. Software reaches everything through one word-addressed register port. Writes take effect at the clock edge and reads return data combinationally. The requesting processor's index comes in on a sideband input, and it selects which processor's local registers the local window reaches.

A second window gives indirect access to another processor's local registers. A selector register, held per processor, picks the processor that this window reaches. Addresses are word offsets. `addr_i[7:4]` picks the window: 0 is the shared registers, 1 is the local window and 2 is the other window. `addr_i[3:0]` picks the register inside the window.

Shared offsets are: 0 config, 1 counter, 2 counter upper word, 3 user-readable counter copy. Local offsets are: 0 control, 1 pending, 2 mask (read), 3 mask clear, 4 mask set, 5 compare map, 6 other selector, 7 identity, 8 compare value.

Top module: `cmp_tmr_unit`

## Requirements
- R1: While the halt bit (config bit 0) is 0, the counter grows by one every clock. While it is 1, the counter holds its value. Writing the config register changes the halt bit.
- R2: A write to the counter (shared offset 1) loads the counter only while it is halted, and is dropped while it is running. Offset 2 always reads 0. Offset 3 reads the counter and ignores writes.
- R3: The config register reads the halt bit at bit 0, NUM_SRC/8-1 in bits [15:8] and NUM_PROC in bits [23:16].
- R4: After reset the counter is 0 and running. For every processor the compare value is 0xFFFFFFFF, pending, control and the other selector are 0, the mask is 0x32 and the compare map is 0x80000000. All interrupt outputs are low.
- R5: When the counter steps to a value equal to a processor's compare value, that processor's pending bit 1 is set. Output `irq_o[p*NUM_PINS+k]` is high exactly when pending bit 1 and mask bit 1 are set, map bit 31 is set and map bits [5:0] equal k.
- R6: A write to the compare value clears pending bit 1 in the same edge, which drops the mapped output, and loads the new value.
- R7: Writing the mask set register sets the mask bits that are 1 in wdata[5:0]. Writing the mask clear register clears those bits. No other mask bit changes.
- R8: A write to the other selector with a value of NUM_PROC or more is ignored. Accesses through the other window reach the selected processor. The identity register returns the index of the processor being accessed.
- R9: A compare-map write whose wdata[5:0] exceeds MAX_PIN (default 5) is ignored. An accepted write stores wdata & 0x8000003F.
- R10: The local window reaches the registers of the processor given on `proc_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | 8 | Word address: window in [7:4], register in [3:0] |
| wdata_i | input | 32 | Write data |
| proc_i | input | IDX_W | Index of the requesting processor |
| rdata_o | output | 32 | Read data for the current address |
| irq_o | output | NUM_PROC*NUM_PINS | Compare interrupt level per processor and pin |

## Verification
The assertions watch the counter's step and hold behaviour on every cycle. They also check that processor 0's pending bit is set on a counter match and cleared by a compare write, and that at most one pin per processor is high and only while pending and mask agree. The bench scenarios are the only place to see the reset values, the config sizing fields, the rejection of out-of-range selector and map writes, and the mask set and clear arithmetic. The same goes for the indirect path through the other window, where a write lands in a different processor's state than the requester's own.

// File: rtl/cmp_tmr_pkg.sv
package cmp_tmr_pkg;
   localparam int unsigned BUS_W   = 32;
   localparam int unsigned MASK_W  = 6;
   localparam int unsigned CMP_BIT = 1;
   localparam int unsigned MAP_ON  = 31;

   typedef enum logic [3:0] {
      WIN_SHARED = 4'h0,
      WIN_LOCAL  = 4'h1,
      WIN_OTHER  = 4'h2
   } win_e;

   localparam logic [3:0] S_CFG     = 4'h0;
   localparam logic [3:0] S_CNT     = 4'h1;
   localparam logic [3:0] S_CNT_HI  = 4'h2;
   localparam logic [3:0] S_USR_CNT = 4'h3;

   localparam logic [3:0] L_CTL      = 4'h0;
   localparam logic [3:0] L_PEND     = 4'h1;
   localparam logic [3:0] L_MASK     = 4'h2;
   localparam logic [3:0] L_MASK_CLR = 4'h3;
   localparam logic [3:0] L_MASK_SET = 4'h4;
   localparam logic [3:0] L_MAP      = 4'h5;
   localparam logic [3:0] L_SEL      = 4'h6;
   localparam logic [3:0] L_IDENT    = 4'h7;
   localparam logic [3:0] L_CMP      = 4'h8;

   localparam logic [MASK_W-1:0] MASK_RST = 6'h32;
   localparam logic [BUS_W-1:0]  MAP_RST  = 32'h8000_0000;
   localparam logic [BUS_W-1:0]  MAP_KEEP = 32'h8000_003F;
endpackage

// File: rtl/cmp_tmr_count.sv
module cmp_tmr_count #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             halt_wr_i,
   input  logic             halt_val_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             halt_o,
   output logic             tick_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] cnt_next_o
);
   logic             halt_q;
   logic [CNT_W-1:0] cnt_q;

   assign cnt_next_o = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
   assign tick_o     = !halt_q;
   assign halt_o     = halt_q;
   assign cnt_o      = cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         halt_q <= 1'b0;
      end else if (halt_wr_i && (halt_val_i != halt_q)) begin
         halt_q <= halt_val_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (halt_q) begin
         if (load_i) cnt_q <= load_val_i;
      end else begin
         cnt_q <= cnt_next_o;
      end
   end
endmodule

// File: rtl/cmp_tmr_local.sv
module cmp_tmr_local
   import cmp_tmr_pkg::*;
#(
   parameter int unsigned CNT_W    = 32,
   parameter int unsigned NUM_PROC = 2,
   parameter int unsigned IDX_W    = 1,
   parameter int unsigned MAX_PIN  = 5,
   parameter int unsigned NUM_PINS = MAX_PIN + 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic [3:0]        off_i,
   input  logic [BUS_W-1:0]  wdata_i,
   input  logic              tick_i,
   input  logic [CNT_W-1:0]  cnt_next_i,
   output logic [MASK_W-1:0] pend_o,
   output logic [MASK_W-1:0] mask_o,
   output logic [BUS_W-1:0]  map_o,
   output logic [CNT_W-1:0]  cmp_o,
   output logic [IDX_W-1:0]  sel_o,
   output logic [NUM_PINS-1:0] pin_o
);
   logic              cmp_pend_q;
   logic [MASK_W-1:0] mask_q;
   logic [BUS_W-1:0]  map_q;
   logic [CNT_W-1:0]  cmp_q;
   logic [IDX_W-1:0]  sel_q;
   logic              cmp_wr, map_ok, sel_ok, fire;

   assign cmp_wr = wr_i && (off_i == L_CMP);
   assign map_ok = (wdata_i[5:0] <= 6'(MAX_PIN));
   assign sel_ok = (wdata_i < BUS_W'(NUM_PROC));
   assign fire   = cmp_pend_q && mask_q[CMP_BIT] && map_q[MAP_ON];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cmp_pend_q <= 1'b0;
      end else if (cmp_wr) begin
         cmp_pend_q <= 1'b0;
      end else if (tick_i && (cnt_next_i == cmp_q)) begin
         cmp_pend_q <= 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mask_q <= MASK_RST;
         map_q  <= MAP_RST;
         cmp_q  <= '1;
         sel_q  <= '0;
      end else if (wr_i) begin
         case (off_i)
            L_MASK_SET: mask_q <= mask_q | wdata_i[MASK_W-1:0];
            L_MASK_CLR: mask_q <= mask_q & ~wdata_i[MASK_W-1:0];
            L_MAP:      if (map_ok) map_q <= wdata_i & MAP_KEEP;
            L_SEL:      if (sel_ok) sel_q <= wdata_i[IDX_W-1:0];
            L_CMP:      cmp_q <= wdata_i[CNT_W-1:0];
            default:    ;
         endcase
      end
   end

   for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
      assign pin_o[k] = fire && (map_q[5:0] == 6'(k));
   end

   always_comb begin
      pend_o          = '0;
      pend_o[CMP_BIT] = cmp_pend_q;
   end
   assign mask_o = mask_q;
   assign map_o  = map_q;
   assign cmp_o  = cmp_q;
   assign sel_o  = sel_q;
endmodule

// File: rtl/cmp_tmr_unit.sv
module cmp_tmr_unit
   import cmp_tmr_pkg::*;
#(
   parameter int unsigned NUM_PROC = 2,
   parameter int unsigned NUM_SRC  = 16,
   parameter int unsigned CNT_W    = 32,
   parameter int unsigned MAX_PIN  = 5,
   parameter int unsigned NUM_PINS = MAX_PIN + 1,
   parameter int unsigned IDX_W    = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1
) (
   input  logic                         clk_i,
   input  logic                         rst_ni,
   input  logic                         req_i,
   input  logic                         we_i,
   input  logic [7:0]                   addr_i,
   input  logic [31:0]                  wdata_i,
   input  logic [IDX_W-1:0]             proc_i,
   output logic [31:0]                  rdata_o,
   output logic [NUM_PROC*NUM_PINS-1:0] irq_o
);
   localparam logic [7:0] SRC_FIELD  = 8'(NUM_SRC / 8 - 1);
   localparam logic [7:0] PROC_FIELD = 8'(NUM_PROC);

   if (NUM_PROC < 1 || NUM_PROC > 255) begin : g_bad_proc
      $error("NUM_PROC must be 1..255");
   end
   if (NUM_SRC < 8 || (NUM_SRC % 8) != 0 || NUM_SRC > 2048) begin : g_bad_src
      $error("NUM_SRC must be a multiple of 8 in 8..2048");
   end
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("CNT_W must be 2..32");
   end
   if (MAX_PIN > 63) begin : g_bad_pin
      $error("MAX_PIN must fit the 6-bit pin field");
   end

   logic [3:0] win, off;
   logic       wr, shared_wr, win_loc;
   assign win       = addr_i[7:4];
   assign off       = addr_i[3:0];
   assign wr        = req_i && we_i;
   assign shared_wr = wr && (win == WIN_SHARED);
   assign win_loc   = (win == WIN_LOCAL) || (win == WIN_OTHER);

   logic             halt, tick, cnt_load;
   logic [CNT_W-1:0] cnt_q, cnt_next;
   assign cnt_load = shared_wr && (off == S_CNT);

   cmp_tmr_count #(.CNT_W(CNT_W)) i_count (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .halt_wr_i  (shared_wr && (off == S_CFG)),
      .halt_val_i (wdata_i[0]),
      .load_i     (cnt_load),
      .load_val_i (wdata_i[CNT_W-1:0]),
      .halt_o     (halt),
      .tick_o     (tick),
      .cnt_o      (cnt_q),
      .cnt_next_o (cnt_next)
   );

   logic [NUM_PROC-1:0][MASK_W-1:0] pend_arr, mask_arr;
   logic [NUM_PROC-1:0][BUS_W-1:0]  map_arr;
   logic [NUM_PROC-1:0][CNT_W-1:0]  cmp_arr;
   logic [NUM_PROC-1:0][IDX_W-1:0]  sel_arr;
   logic [NUM_PROC-1:0]             cmp_wr_vec;
   logic [IDX_W-1:0]                tgt;

   if (NUM_PROC == 1) begin : g_single
      assign tgt = '0;
   end else begin : g_multi
      assign tgt = (win == WIN_OTHER) ? sel_arr[proc_i] : proc_i;
   end

   for (genvar p = 0; p < NUM_PROC; p++) begin : g_proc
      logic lwr;
      assign lwr           = wr && win_loc && (tgt == IDX_W'(p));
      assign cmp_wr_vec[p] = lwr && (off == L_CMP);

      cmp_tmr_local #(
         .CNT_W    (CNT_W),
         .NUM_PROC (NUM_PROC),
         .IDX_W    (IDX_W),
         .MAX_PIN  (MAX_PIN),
         .NUM_PINS (NUM_PINS)
      ) i_local (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .wr_i       (lwr),
         .off_i      (off),
         .wdata_i    (wdata_i),
         .tick_i     (tick),
         .cnt_next_i (cnt_next),
         .pend_o     (pend_arr[p]),
         .mask_o     (mask_arr[p]),
         .map_o      (map_arr[p]),
         .cmp_o      (cmp_arr[p]),
         .sel_o      (sel_arr[p]),
         .pin_o      (irq_o[p*NUM_PINS +: NUM_PINS])
      );
   end

   always_comb begin
      rdata_o = '0;
      if (win == WIN_SHARED) begin
         case (off)
            S_CFG:     rdata_o = {8'h00, PROC_FIELD, SRC_FIELD, 7'h00, halt};
            S_CNT,
            S_USR_CNT: rdata_o = BUS_W'(cnt_q);
            default:   rdata_o = '0;
         endcase
      end else if (win_loc) begin
         case (off)
            L_PEND:  rdata_o = BUS_W'(pend_arr[tgt]);
            L_MASK:  rdata_o = BUS_W'(mask_arr[tgt]);
            L_MAP:   rdata_o = map_arr[tgt];
            L_SEL:   rdata_o = BUS_W'(sel_arr[tgt]);
            L_IDENT: rdata_o = BUS_W'(tgt);
            L_CMP:   rdata_o = BUS_W'(cmp_arr[tgt]);
            default: rdata_o = '0;
         endcase
      end
   end
endmodule

// File: rtl/cmp_tmr_chk.sv
module cmp_tmr_chk #(
   parameter int unsigned CNT_W    = 32,
   parameter int unsigned NUM_PINS = 6
) (
   input logic                clk_i,
   input logic                rst_ni,
   input logic                halt_i,
   input logic                load_i,
   input logic                tick_i,
   input logic [CNT_W-1:0]    cnt_i,
   input logic [CNT_W-1:0]    nxt_i,
   input logic [CNT_W-1:0]    cmp0_i,
   input logic                cmpwr0_i,
   input logic [5:0]          pend0_i,
   input logic [5:0]          mask0_i,
   input logic [NUM_PINS-1:0] pins0_i
);
   p_halt_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (halt_i && !load_i) |=> (cnt_i == $past(cnt_i)));

   p_run_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !halt_i |=> (cnt_i == $past(cnt_i) + 1'b1));

   p_match_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && (nxt_i == cmp0_i) && !cmpwr0_i) |=> pend0_i[1]);

   p_cmp_write_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmpwr0_i |=> !pend0_i[1]);

   p_one_pin_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(pins0_i));

   p_pin_needs_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|pins0_i) |-> (pend0_i[1] && mask0_i[1]));
endmodule

bind cmp_tmr_unit cmp_tmr_chk #(.CNT_W(CNT_W), .NUM_PINS(NUM_PINS)) i_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .halt_i   (halt),
   .load_i   (cnt_load),
   .tick_i   (tick),
   .cnt_i    (cnt_q),
   .nxt_i    (cnt_next),
   .cmp0_i   (cmp_arr[0]),
   .cmpwr0_i (cmp_wr_vec[0]),
   .pend0_i  (pend_arr[0]),
   .mask0_i  (mask_arr[0]),
   .pins0_i  (irq_o[NUM_PINS-1:0])
);

// File: tb/test_cmp_tmr_unit.sv
`timescale 1ns/1ps
module test_cmp_tmr_unit;
   localparam int NP = 2;
   localparam int NPIN = 6;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req = 1'b0, we = 1'b0;
   logic [7:0]      addr = '0;
   logic [31:0]     wdata = '0;
   logic [0:0]      proc = '0;
   logic [31:0]     rdata;
   logic [NP*NPIN-1:0] irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   cmp_tmr_unit i_cmp_tmr_unit (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
      .wdata_i(wdata), .proc_i(proc), .rdata_o(rdata), .irq_o(irq));

   localparam logic [7:0] CFG = 8'h00, CNT = 8'h01, CNTHI = 8'h02, UCNT = 8'h03;
   localparam logic [7:0] LOC = 8'h10, OTH = 8'h20;
   localparam logic [7:0] CTL = 0, PEND = 1, MASK = 2, MCLR = 3, MSET = 4,
                          MAP = 5, SEL = 6, IDENT = 7, CMPV = 8;

   task automatic check(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req_tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [0:0] p);
      @(negedge clk);
      req = 1; we = 1; addr = a; wdata = d; proc = p;
      @(posedge clk); #1;
      req = 0; we = 0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [0:0] p, output logic [31:0] d);
      @(negedge clk);
      req = 1; we = 0; addr = a; proc = p;
      #1 d = rdata;
      req = 0;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      check("R4 irq", 32'(irq), 32'h0);
      rd(CFG, 0, d);  check("R3 cfg", d, 32'h0002_0100);
      rd(LOC+CMPV, 0, d); check("R4 cmp", d, 32'hFFFF_FFFF);
      rd(LOC+PEND, 0, d); check("R4 pend", d, 0);
      rd(LOC+MASK, 0, d); check("R4 mask", d, 32'h32);
      rd(LOC+MAP, 0, d);  check("R4 map", d, 32'h8000_0000);
      rd(LOC+SEL, 0, d);  check("R4 sel", d, 0);
      rd(LOC+CTL, 0, d);  check("R4 ctl", d, 0);
      rd(LOC+IDENT, 1, d); check("R10 ident p1", d, 1);
      rd(LOC+IDENT, 0, d); check("R10 ident p0", d, 0);
   endtask

   task automatic t_count_run;
      logic [31:0] a, b;
      rd(CNT, 0, a); rd(CNT, 0, b); check("R1 step", b, a + 1);
      wr(CFG, 1, 0);
      rd(CFG, 0, a); check("R3 halt bit", a, 32'h0002_0101);
      rd(CNT, 0, a); repeat (3) @(negedge clk); rd(CNT, 0, b);
      check("R1 hold", b, a);
      wr(CFG, 1, 0);
      rd(CNT, 0, b); check("R1 rewrite same", b, a);
      wr(CFG, 0, 0);
      rd(CNT, 0, a); rd(CNT, 0, b); check("R1 restart", b, a + 1);
   endtask

   task automatic t_count_write;
      logic [31:0] d;
      wr(CNT, 32'h1234_0000, 0);
      rd(CNT, 0, d); check("R2 running write dropped", 32'(d < 32'h1000), 1);
      wr(CFG, 1, 0);
      wr(CNT, 32'h0000_1234, 0);
      rd(CNT, 0, d);  check("R2 halted load", d, 32'h1234);
      rd(CNTHI, 0, d); check("R2 hi zero", d, 0);
      wr(UCNT, 32'h55, 0);
      rd(UCNT, 0, d); check("R2 user copy", d, 32'h1234);
      wr(CFG, 0, 0);
   endtask

   task automatic t_mask;
      logic [31:0] d;
      wr(LOC+MSET, 32'h05, 0); rd(LOC+MASK, 0, d); check("R7 set", d, 32'h37);
      wr(LOC+MCLR, 32'h24, 0); rd(LOC+MASK, 0, d); check("R7 clr", d, 32'h13);
      wr(LOC+MSET, 32'h20, 0); rd(LOC+MASK, 0, d); check("R7 set2", d, 32'h33);
      wr(LOC+MCLR, 32'h01, 0); rd(LOC+MASK, 0, d); check("R7 clr2", d, 32'h32);
   endtask

   task automatic t_map;
      logic [31:0] d;
      wr(LOC+MAP, 32'h8000_0007, 0); rd(LOC+MAP, 0, d); check("R9 bad pin", d, 32'h8000_0000);
      wr(LOC+MAP, 32'h0000_0005, 0); rd(LOC+MAP, 0, d); check("R9 max pin", d, 32'h5);
      wr(LOC+MAP, 32'hFFFF_FFC3, 0); rd(LOC+MAP, 0, d); check("R9 keep bits", d, 32'h8000_0003);
      wr(LOC+MAP, 32'h8000_0000, 0);
   endtask

   task automatic t_other;
      logic [31:0] d;
      wr(LOC+SEL, 5, 0); rd(LOC+SEL, 0, d); check("R8 sel out of range", d, 0);
      wr(LOC+SEL, 1, 0); rd(LOC+SEL, 0, d); check("R8 sel", d, 1);
      rd(OTH+IDENT, 0, d); check("R8 ident other", d, 1);
      wr(OTH+CMPV, 32'h77, 0);
      rd(LOC+CMPV, 1, d); check("R8 other cmp p1", d, 32'h77);
      rd(LOC+CMPV, 0, d); check("R10 own cmp p0", d, 32'hFFFF_FFFF);
      wr(OTH+MCLR, 32'h10, 0);
      rd(LOC+MASK, 1, d); check("R8 other mask p1", d, 32'h22);
      rd(LOC+MASK, 0, d); check("R10 own mask p0", d, 32'h32);
      wr(OTH+CMPV, 32'hFFFF_FFFF, 0);
   endtask

   task automatic t_match;
      logic [31:0] d;
      wr(CFG, 1, 0);
      wr(CNT, 100, 0);
      wr(LOC+MAP, 32'h8000_0002, 0);
      wr(LOC+CMPV, 105, 0);
      wr(CFG, 0, 0);
      rd(LOC+PEND, 0, d); check("R5 before match", d, 0);
      repeat (8) @(negedge clk);
      rd(LOC+PEND, 0, d); check("R5 pend set", d, 2);
      check("R5 irq pin2", 32'(irq), 32'h4);
      wr(LOC+CMPV, 32'hFFFF_FFFF, 0);
      rd(LOC+PEND, 0, d); check("R6 pend cleared", d, 0);
      check("R6 irq low", 32'(irq), 0);
      rd(LOC+CMPV, 0, d); check("R6 cmp loaded", d, 32'hFFFF_FFFF);
      wr(CFG, 1, 0);
      wr(CNT, 200, 0);
      wr(LOC+MCLR, 32'h02, 0);
      wr(LOC+CMPV, 203, 0);
      wr(CFG, 0, 0);
      repeat (8) @(negedge clk);
      rd(LOC+PEND, 0, d); check("R5 pend masked", d, 2);
      check("R5 irq masked", 32'(irq), 0);
      wr(LOC+MSET, 32'h02, 0);
      #1 check("R5 irq unmasked", 32'(irq), 32'h4);
      wr(LOC+CMPV, 32'hFFFF_FFFF, 0);
      #1 check("R6 irq cleared", 32'(irq), 0);
   endtask

   task automatic summary;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_count_run();
      t_count_write();
      t_mask();
      t_map();
      t_other();
      t_match();
      done = 1;
      summary();
   end

   initial begin
      #50000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         summary();
      end
   end
endmodule